// File: doc/BRIEF.md
# Host Read Shadow Bridge

This block lets an 8-bit processor bus read a bank of 32-bit internal registers whose contents may change on any clock. The processor first asks for a copy of one register, and the block latches all 32 bits of it into a shadow word in a single edge. The processor then pulls that copy out one byte at a time, so the bytes it assembles always come from the same instant.

The processor address is nine bits wide. The top bit asks for a fresh copy. The next six bits name the internal register by quadlet index. The lowest two bits pick a byte lane of the shadow word. Lane selection is purely combinational, so external logic may hold one long read and step the two low bits through 0 to 3 to collect the whole word.

An optional mode, enabled by an input pin, treats any read of lane 0 as a copy request. Software that reads bytes in ascending order then refreshes the shadow without setting the top address bit.

Top module: `host_rd_shadow`

## Requirements
- R1: After reset the shadow word is zero, so a read with the copy bit (bit 8) low returns 0 on every lane.
- R2: While a read is active, the data output shows shadow bits [8n+7:8n] for lane n = address bits [1:0] (lane 0 is the least significant byte), and it follows a lane change in the same cycle.
- R3: The register index output always equals address bits [7:2].
- R4: In the first cycle of a read with bit 8 high, `reg_req` is high for exactly that cycle, and the shadow takes `reg_rdata` on the next rising clock edge.
- R5: In that copy cycle the data output already shows the selected lane of `reg_rdata`.
- R6: A read with bit 8 low (and no automatic copy) leaves the shadow unchanged, even when the internal register value changes.
- R7: A read held active for several cycles copies only in its first cycle. Later changes of lane or of register data during that same read show the value copied at the start.
- R8: Lanes may be read in any order and any number of times, and each read returns the same shadow byte.
- R9: With `auto_copy_en` high, a read with lane 0 acts as a copy request even when bit 8 is low. Reads of lanes 1 to 3 do not copy.
- R10: With `auto_copy_en` low, a lane-0 read with bit 8 low does not copy.
- R11: `cpu_doe` is high exactly while `cpu_cs` and `cpu_rd` are both high. At all other times `cpu_dout` is zero.
- R12: `reg_req` stays low unless `cpu_cs` and `cpu_rd` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 9 | Bit 8 requests a copy, bits 7:2 give the register index, bits 1:0 give the byte lane |
| cpu_cs | input | 1 | Chip select, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| auto_copy_en | input | 1 | Treats a lane-0 read as a copy request |
| cpu_dout | output | 8 | Selected byte, zero when idle |
| cpu_doe | output | 1 | Output enable for the data bus |
| reg_idx | output | 6 | Quadlet index of the internal register |
| reg_req | output | 1 | Copy strobe toward the register bank |
| reg_rdata | input | 32 | Current value of the indexed register |

## Verification
The bench sweeps every register index and every lane, with and without the copy bit and with the automatic mode on and off. The register data changes between reads, so a shadow that tracks live data fails the hold checks instead of passing by accident. A long held read steps through all lanes while the data keeps changing. A design that copied on every cycle of that read, instead of only the leading one, would return torn words. Each copy cycle checks that the new byte is visible at once, which catches a mux that shows stale data until the edge. Chip select and read strobe are also raised alone, which catches a copy strobe that ignores one of them.

// File: rtl/host_rd_pkg.sv
package host_rd_pkg;
    localparam int ADDR_W_DEF = 9;
    localparam int BYTE_W_DEF = 8;
    localparam int WORD_W_DEF = 32;

    function automatic int lanes_of(input int word_w, input int byte_w);
        return word_w / byte_w;
    endfunction
endpackage

// File: rtl/host_rd_decode.sv
module host_rd_decode #(
    parameter int ADDR_W = 9,
    parameter int LANE_W = 2,
    localparam int IDX_W = ADDR_W - 1 - LANE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs,
    input  logic              rd,
    input  logic              auto_en,
    input  logic              seen_q,
    output logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] lane,
    output logic              access,
    output logic              copy_req
);
    logic want_copy;

    always_comb begin
        idx       = addr[ADDR_W-2:LANE_W];
        lane      = addr[LANE_W-1:0];
        access    = cs & rd;
        want_copy = addr[ADDR_W-1] | (auto_en & (lane == '0));
        copy_req  = access & want_copy & ~seen_q;
    end
endmodule

// File: rtl/host_rd_store.sv
module host_rd_store #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic              copy_req,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] shadow_q,
    output logic              seen_q
);
    typedef struct packed {
        logic [WORD_W-1:0] shadow;
        logic              seen;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = access;
        if (copy_req) begin
            st_d.shadow = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_q = st_q.shadow;
    assign seen_q   = st_q.seen;
endmodule

// File: rtl/host_rd_bytesel.sv
module host_rd_bytesel #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] shadow,
    input  logic [WORD_W-1:0] rdata,
    input  logic              copy_req,
    input  logic              access,
    input  logic [LANE_W-1:0] lane,
    output logic [BYTE_W-1:0] dout,
    output logic              doe
);
    logic [WORD_W-1:0] word;
    logic [BYTE_W-1:0] lane_bytes [LANES];

    assign word = copy_req ? rdata : shadow;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        doe  = access;
        dout = access ? lane_bytes[lane] : '0;
    end
endmodule

// File: rtl/host_rd_shadow.sv
module host_rd_shadow
    import host_rd_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int WORD_W = WORD_W_DEF,
    localparam int LANES  = lanes_of(WORD_W, BYTE_W),
    localparam int LANE_W = $clog2(LANES),
    localparam int IDX_W  = ADDR_W - 1 - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_cs,
    input  logic              cpu_rd,
    input  logic              auto_copy_en,
    output logic [BYTE_W-1:0] cpu_dout,
    output logic              cpu_doe,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              reg_req,
    input  logic [WORD_W-1:0] reg_rdata
);
    logic [LANE_W-1:0] lane;
    logic              access;
    logic              copy_req;
    logic              seen_q;
    logic [WORD_W-1:0] shadow_q;

    host_rd_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dec (
        .addr     (cpu_addr),
        .cs       (cpu_cs),
        .rd       (cpu_rd),
        .auto_en  (auto_copy_en),
        .seen_q   (seen_q),
        .idx      (reg_idx),
        .lane     (lane),
        .access   (access),
        .copy_req (copy_req)
    );

    host_rd_store #(.WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (access),
        .copy_req (copy_req),
        .rdata    (reg_rdata),
        .shadow_q (shadow_q),
        .seen_q   (seen_q)
    );

    host_rd_bytesel #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_sel (
        .shadow   (shadow_q),
        .rdata    (reg_rdata),
        .copy_req (copy_req),
        .access   (access),
        .lane     (lane),
        .dout     (cpu_dout),
        .doe      (cpu_doe)
    );

    assign reg_req = copy_req;
endmodule

// File: rtl/host_rd_shadow_chk.sv
module host_rd_shadow_chk #(
    parameter int ADDR_W = 9,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_cs,
    input logic              cpu_rd,
    input logic [BYTE_W-1:0] cpu_dout,
    input logic              cpu_doe,
    input logic              reg_req,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [WORD_W-1:0] shadow_q
);
    // R12: copy strobe only inside a selected read
    assert_req_qualified_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> (cpu_cs && cpu_rd));

    // R4: the shadow holds the register value seen in the copy cycle
    assert_copy_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> (shadow_q == $past(reg_rdata)));

    // R6: without a copy strobe the shadow does not move
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_req |=> $stable(shadow_q));

    // R7: a held read never copies twice in a row
    assert_single_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> !reg_req);

    // R11: bus idle while not selected for read
    assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_cs && cpu_rd) |-> (cpu_dout == '0 && !cpu_doe));

    // R2: a read without a copy shows a byte of the stored word
    assert_lane_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_doe && !reg_req) |->
        (cpu_dout == shadow_q[cpu_addr[1:0]*BYTE_W +: BYTE_W]));
endmodule

bind host_rd_shadow host_rd_shadow_chk #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_cs    (cpu_cs),
    .cpu_rd    (cpu_rd),
    .cpu_dout  (cpu_dout),
    .cpu_doe   (cpu_doe),
    .reg_req   (reg_req),
    .reg_rdata (reg_rdata),
    .shadow_q  (shadow_q)
);

// File: tb/tb_host_rd_shadow.sv
module tb_host_rd_shadow;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [8:0]  cpu_addr = '0;
    logic        cpu_cs = 0;
    logic        cpu_rd = 0;
    logic        auto_copy_en = 0;
    logic [7:0]  cpu_dout;
    logic        cpu_doe;
    logic [5:0]  reg_idx;
    logic        reg_req;
    logic [31:0] reg_rdata;
    logic [31:0] salt = 32'h1234_5678;
    logic [31:0] sh_model = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    host_rd_shadow dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_cs(cpu_cs),
        .cpu_rd(cpu_rd), .auto_copy_en(auto_copy_en), .cpu_dout(cpu_dout),
        .cpu_doe(cpu_doe), .reg_idx(reg_idx), .reg_req(reg_req),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] bank_word(input logic [5:0] idx, input logic [31:0] s);
        return (32'h9E37_79B9 * ({26'd0, idx} + 32'd1)) ^ s;
    endfunction

    assign reg_rdata = bank_word(reg_idx, salt);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bump();
        salt = salt * 32'd1103515245 + 32'd12345;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One single-cycle read followed by an idle cycle
    task automatic do_read(input logic [8:0] a);
        logic        copy;
        logic [31:0] word;
        @(negedge clk);
        cpu_addr = a; cpu_cs = 1; cpu_rd = 1;
        #1;
        copy = a[8] | (auto_copy_en & (a[1:0] == 2'd0));
        word = copy ? bank_word(a[7:2], salt) : sh_model;
        check(copy ? "R5" : (auto_copy_en ? "R9" : "R2/R6/R8/R10"),
              {24'd0, cpu_dout}, {24'd0, word[a[1:0]*8 +: 8]});
        check("R4", {31'd0, reg_req}, {31'd0, copy});
        check("R3", {26'd0, reg_idx}, {26'd0, a[7:2]});
        check("R11", {31'd0, cpu_doe}, 32'd1);
        @(negedge clk);
        cpu_cs = 0; cpu_rd = 0;
        if (copy) sh_model = word;
        bump();
        #1;
        check("R11", {24'd0, cpu_dout}, 32'd0);
        check("R11", {31'd0, cpu_doe}, 32'd0);
        check("R12", {31'd0, reg_req}, 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
            summary();
        end
    end

    initial begin
        #1;
        check("R11", {24'd0, cpu_dout}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: shadow starts at zero on all lanes
        for (int l = 0; l < 4; l++) do_read({1'b0, 6'd9, l[1:0]});
        check("R1", sh_model, 32'd0);

        // Sweep every index: copy on one lane, then plain reads in mixed order
        for (int i = 0; i < 64; i++) begin
            do_read({1'b1, i[5:0], i[1:0]});
            do_read({1'b0, i[5:0], 2'd3});
            do_read({1'b0, i[5:0], 2'd0});   // R10: lane 0 without auto mode
            do_read({1'b0, i[5:0], 2'd2});
            do_read({1'b0, i[5:0], 2'd1});
            do_read({1'b0, i[5:0], 2'd1});   // R8: repeat
            do_read({1'b0, 6'(63 - i), 2'd2}); // R6: other index, no copy
        end
        // Worked example: byte 2 of the register at offset 0x54
        do_read(9'h156);

        // R9: automatic copy on lane 0 only
        auto_copy_en = 1;
        for (int i = 0; i < 64; i++) begin
            for (int l = 0; l < 4; l++) do_read({1'b0, i[5:0], l[1:0]});
            do_read({1'b0, i[5:0], 2'd3});
        end
        auto_copy_en = 0;

        // R7: one held read steps through all lanes while data keeps changing
        @(negedge clk);
        cpu_addr = {1'b1, 6'd21, 2'd0}; cpu_cs = 1; cpu_rd = 1;
        #1;
        sh_model = bank_word(6'd21, salt);
        check("R7", {31'd0, reg_req}, 32'd1);
        check("R7", {24'd0, cpu_dout}, {24'd0, sh_model[7:0]});
        for (int k = 1; k < 12; k++) begin
            @(negedge clk);
            bump();
            cpu_addr[1:0] = k[1:0];
            #1;
            check("R7", {31'd0, reg_req}, 32'd0);
            check("R7", {24'd0, cpu_dout}, {24'd0, sh_model[k[1:0]*8 +: 8]});
        end
        @(negedge clk);
        cpu_cs = 0; cpu_rd = 0;

        // R12: chip select alone, then read strobe alone, with copy bit set
        @(negedge clk);
        cpu_addr = {1'b1, 6'd40, 2'd1}; cpu_cs = 1; cpu_rd = 0; bump();
        #1;
        check("R12", {31'd0, reg_req}, 32'd0);
        check("R11", {24'd0, cpu_dout}, 32'd0);
        @(negedge clk);
        cpu_cs = 0; cpu_rd = 1; bump();
        #1;
        check("R12", {31'd0, reg_req}, 32'd0);
        check("R11", {31'd0, cpu_doe}, 32'd0);
        @(negedge clk);
        cpu_rd = 0;
        for (int l = 0; l < 4; l++) do_read({1'b0, 6'd40, l[1:0]});

        summary();
    end
endmodule